// File: doc/BRIEF.md
# DDR2 Write Termination Timing Generator

This block drives the on-die termination control pin of a DDR2 device so that termination is on for every write data burst. Each cycle it takes a write command strobe, the programmed CAS latency, a burst length select and an early-mode bit. It works out when the termination pin must rise and fall after each write command. The device is taken to have a termination turn-on delay of 2 clocks and a turn-off delay of 2.5 clocks. Write latency is CAS latency minus one, with no additive latency.

In normal mode the pin rises two clocks before the write data and stays high for as many clocks as the burst lasts (half the beat count). In early mode it rises one clock sooner and falls one clock later. Early mode needs a larger CAS latency. It also needs the read-to-write turnaround to be one clock longer than the device minimum, and the block reports that extra clock on an output. When the CAS latency does not meet the minimum for the selected mode, or is above what the block can schedule, the block raises a configuration error and ignores write commands.

A write command adds its termination window to a schedule that runs ahead of the pin. Windows from writes that overlap or follow each other directly merge into one continuous high level, with no drop between bursts.

Top module: `ddr2_odt_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `odt`, `cfg_err` and `rdwr_pad` are all 0.
- R2: In normal mode (`early_en`=0) with CAS latency CL of 4 or more, a write command sampled in cycle c makes `odt` high from cycle c+CL-3 for exactly as many cycles as the burst lasts.
- R3: In early mode (`early_en`=1) with CL of 5 or more, a write command in cycle c makes `odt` high from cycle c+CL-4 for the burst length in clocks plus 2 cycles.
- R4: `bl8`=0 selects a 4-beat burst (2 clocks) and `bl8`=1 selects an 8-beat burst (4 clocks). An `odt` pulse is never shorter than 2 cycles.
- R5: In normal mode a CL below 4 sets `cfg_err` in the next cycle, and write commands are ignored: `odt` stays low.
- R6: In early mode a CL below 5 sets `cfg_err` in the next cycle, and write commands are ignored.
- R7: A CL above the parameter `CL_MAX` sets `cfg_err` in the next cycle, in either mode.
- R8: When a second write command comes while the termination window of the first is pending or active, `odt` stays high without a gap until the later window ends.
- R9: `rdwr_pad` is 1 one cycle after `early_en` is 1, and 0 one cycle after `early_en` is 0. It gives the one extra turnaround clock that early mode needs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_cmd | input | 1 | Write command issued this cycle |
| cas_lat | input | CLW | Programmed CAS latency in clocks |
| bl8 | input | 1 | Burst length select: 0 = 4 beats, 1 = 8 beats |
| early_en | input | 1 | Early termination mode |
| odt | output | 1 | Termination control to the DRAM |
| cfg_err | output | 1 | CAS latency not allowed for the selected mode |
| rdwr_pad | output | 1 | One extra read-to-write turnaround clock needed |

## Verification
The assertions check the behaviours that hold on every cycle: the quiet state after reset, the error flag following each illegal CAS latency one cycle later, the turnaround output following the mode bit, and the two-cycle minimum width of an `odt` pulse. The exact cycle at which `odt` rises and falls relative to a command depends on CAS latency, burst length and mode together. Only the bench's scenarios can show this, measuring the offset of each edge for CL 4 to 6, both burst lengths and both modes. The same holds for the merged window of back-to-back and overlapping writes, and for writes being ignored under an illegal setting.

// File: rtl/ddr2_odt_pkg.sv
package ddr2_odt_pkg;

    // Width of the offset and span fields of a termination window.
    localparam int unsigned OFS_W = 8;

    // Smallest CAS latency allowed in each mode.
    localparam int unsigned NORM_CL_MIN  = 4;
    localparam int unsigned EARLY_CL_MIN = 5;

    // Device turn-on delay in whole clocks; the pin leads the data by this much.
    localparam int unsigned TURN_ON_CLK = 2;

    // Termination window for one write, measured from the command cycle.
    typedef struct packed {
        logic             ok;     // configuration legal
        logic [OFS_W-1:0] start;  // first high cycle offset (>= 1 when ok)
        logic [OFS_W-1:0] span;   // number of high cycles
    } odt_win_t;

endpackage

// File: rtl/odt_cfg_check.sv
module odt_cfg_check
    import ddr2_odt_pkg::*;
#(
    parameter int unsigned CLW    = 4,
    parameter int unsigned CL_MAX = 7
) (
    input  logic [CLW-1:0] cas_lat,
    input  logic           bl8,
    input  logic           early_en,
    output odt_win_t       win
);

    localparam int unsigned CL_FLOOR_N = NORM_CL_MIN;
    localparam int unsigned CL_FLOOR_E = EARLY_CL_MIN;

    int unsigned cl;
    int unsigned wl;
    int unsigned lead;
    int unsigned burst_clk;
    logic        legal;

    always_comb begin
        cl        = int'(cas_lat);
        wl        = (cl > 0) ? cl - 1 : 0;
        // Normal mode leads the data by the turn-on delay, early mode by one more.
        lead      = TURN_ON_CLK + (early_en ? 1 : 0);
        burst_clk = bl8 ? 4 : 2;
        legal     = (cl <= CL_MAX) &&
                    (cl >= (early_en ? CL_FLOOR_E : CL_FLOOR_N));

        win.ok    = legal;
        win.start = legal ? OFS_W'(wl - lead) : '0;
        // Early mode adds the earlier rise and one clock of extra hold.
        win.span  = legal ? OFS_W'(burst_clk + (early_en ? 2 : 0)) : '0;
    end

endmodule

// File: rtl/odt_window_mask.sv
module odt_window_mask
    import ddr2_odt_pkg::*;
#(
    parameter int unsigned DEPTH = 9
) (
    input  logic             fire,
    input  odt_win_t         win,
    output logic [DEPTH-1:0] add_mask
);

    // Bit k stands for offset k+1 from the command cycle.
    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        localparam int unsigned OFS = k + 1;
        always_comb begin
            add_mask[k] = fire &&
                          (OFS >= int'(win.start)) &&
                          (OFS <  int'(win.start) + int'(win.span));
        end
    end

endmodule

// File: rtl/ddr2_odt_gen.sv
module ddr2_odt_gen
    import ddr2_odt_pkg::*;
#(
    parameter int unsigned CLW    = 4,
    parameter int unsigned CL_MAX = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_cmd,
    input  logic [CLW-1:0] cas_lat,
    input  logic           bl8,
    input  logic           early_en,
    output logic           odt,
    output logic           cfg_err,
    output logic           rdwr_pad
);

    // Latest window end: early mode at CL_MAX ends at offset CL_MAX+1.
    localparam int unsigned DEPTH = CL_MAX + 2;

    typedef struct packed {
        logic [DEPTH-1:0] sched;
        logic             odt;
        logic             err;
        logic             pad;
    } state_t;

    state_t           st_d, st_q;
    odt_win_t         win;
    logic [DEPTH-1:0] add_mask;
    logic [DEPTH-1:0] merged;

    odt_cfg_check #(.CLW(CLW), .CL_MAX(CL_MAX)) u_cfg (
        .cas_lat  (cas_lat),
        .bl8      (bl8),
        .early_en (early_en),
        .win      (win)
    );

    odt_window_mask #(.DEPTH(DEPTH)) u_mask (
        .fire     (wr_cmd && win.ok),
        .win      (win),
        .add_mask (add_mask)
    );

    always_comb begin
        // Union with the pending schedule keeps merged windows gap-free.
        merged    = st_q.sched | add_mask;
        st_d      = st_q;
        st_d.odt  = merged[0];
        st_d.sched = merged >> 1;
        st_d.err  = !win.ok;
        st_d.pad  = early_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign odt      = st_q.odt;
    assign cfg_err  = st_q.err;
    assign rdwr_pad = st_q.pad;

endmodule

// File: rtl/ddr2_odt_gen_chk.sv
module ddr2_odt_gen_chk #(
    parameter int unsigned CLW    = 4,
    parameter int unsigned CL_MAX = 7
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_cmd,
    input logic [CLW-1:0] cas_lat,
    input logic           bl8,
    input logic           early_en,
    input logic           odt,
    input logic           cfg_err,
    input logic           rdwr_pad
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!odt && !cfg_err && !rdwr_pad));

    a_r4_min_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(odt) |=> odt);

    a_r5_normal_low_cl: assert property (@(posedge clk) disable iff (!rst_n)
        (!early_en && int'(cas_lat) < 4) |=> cfg_err);

    a_r6_early_low_cl: assert property (@(posedge clk) disable iff (!rst_n)
        (early_en && int'(cas_lat) < 5) |=> cfg_err);

    a_r7_cl_too_high: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cas_lat) > CL_MAX) |=> cfg_err);

    a_r9_pad_follows: assert property (@(posedge clk) disable iff (!rst_n)
        early_en |=> rdwr_pad);

    a_r9_pad_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !early_en |=> !rdwr_pad);

endmodule

bind ddr2_odt_gen ddr2_odt_gen_chk #(.CLW(CLW), .CL_MAX(CL_MAX)) u_chk (.*);

// File: tb/sim_ddr2_odt_gen.sv
`timescale 1ns/1ps
module sim_ddr2_odt_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_cmd = 1'b0;
    logic [3:0] cas_lat = 4'd4;
    logic       bl8 = 1'b0;
    logic       early_en = 1'b0;
    logic       odt, cfg_err, rdwr_pad;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    ddr2_odt_gen #(.CLW(4), .CL_MAX(7)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .cas_lat(cas_lat),
        .bl8(bl8), .early_en(early_en), .odt(odt), .cfg_err(cfg_err),
        .rdwr_pad(rdwr_pad)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One write at offset 0; optional second write at offset gap (0 = none).
    // Measures first rise, final fall and how many rises occurred.
    task automatic run_pattern(input int cl, input bit b8, input bit early, input int gap,
                               output int rise, output int fall, output int rises,
                               output int err_seen);
        bit prev = 0;
        rise = -1; fall = -1; rises = 0; err_seen = 0;
        @(negedge clk);
        cas_lat = 4'(cl); bl8 = b8; early_en = early;
        @(negedge clk);
        @(negedge clk);
        err_seen = int'(cfg_err);
        wr_cmd = 1'b1;
        for (int k = 1; k <= 30; k++) begin
            @(negedge clk);
            wr_cmd = (gap != 0 && k == gap);
            if (odt && !prev) begin
                rises++;
                if (rise < 0) rise = k;
            end
            if (!odt && prev) fall = k;
            prev = odt;
        end
        wr_cmd = 1'b0;
    endtask

    task automatic t_single(input string req, input int cl, input bit b8, input bit early);
        int r, f, n, e;
        int st  = early ? cl - 4 : cl - 3;
        int len = (b8 ? 4 : 2) + (early ? 2 : 0);
        run_pattern(cl, b8, early, 0, r, f, n, e);
        check({req, " rise offset"}, r, st);
        check({req, " fall offset"}, f, st + len);
    endtask

    task automatic t_merge(input string req, input int cl, input bit b8, input bit early,
                           input int gap);
        int r, f, n, e;
        int st  = early ? cl - 4 : cl - 3;
        int len = (b8 ? 4 : 2) + (early ? 2 : 0);
        run_pattern(cl, b8, early, gap, r, f, n, e);
        check({req, " merged rise"}, r, st);
        check({req, " merged fall"}, f, gap + st + len);
        check({req, " single pulse"}, n, 1);
    endtask

    task automatic t_illegal(input string req, input int cl, input bit early);
        int r, f, n, e;
        run_pattern(cl, 1'b1, early, 0, r, f, n, e);
        check({req, " cfg_err"}, e, 1);
        check({req, " odt suppressed"}, n, 0);
    endtask

    task automatic t_pad();
        @(negedge clk);
        cas_lat = 4'd5; early_en = 1'b1;
        @(negedge clk);
        check("R9 pad set", int'(rdwr_pad), 1);
        early_en = 1'b0;
        @(negedge clk);
        check("R9 pad clear", int'(rdwr_pad), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check("R1 odt in reset", int'(odt), 0);
        check("R1 cfg_err in reset", int'(cfg_err), 0);
        check("R1 pad in reset", int'(rdwr_pad), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 odt after reset", int'(odt), 0);

        // R2 and R4: normal mode, CL 4..6, both burst lengths
        for (int cl = 4; cl <= 6; cl++) begin
            t_single("R2 R4 normal BL4", cl, 1'b0, 1'b0);
            t_single("R2 R4 normal BL8", cl, 1'b1, 1'b0);
        end
        // R3: early mode, CL 5..6, both burst lengths
        for (int cl = 5; cl <= 6; cl++) begin
            t_single("R3 early BL4", cl, 1'b0, 1'b1);
            t_single("R3 early BL8", cl, 1'b1, 1'b1);
        end
        // R8: back-to-back and overlapping writes
        t_merge("R8 back-to-back BL8", 5, 1'b1, 1'b0, 4);
        t_merge("R8 overlap BL8", 6, 1'b1, 1'b0, 2);
        t_merge("R8 early back-to-back BL4", 6, 1'b0, 1'b1, 2);
        // R5, R6, R7: illegal latencies
        t_illegal("R5 normal CL3", 3, 1'b0);
        t_illegal("R6 early CL4", 4, 1'b1);
        t_illegal("R7 CL9", 9, 1'b0);
        // recovery after illegal setting
        t_single("R2 after error", 4, 1'b1, 1'b0);
        t_pad();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule